// File: doc/BRIEF.md
# LED Driver Fault and Sequencing Supervisor

This block is the digital supervisor of a switching LED driver. It watches single-bit comparator flags and a dimming input, and drives three enables: one for the power switching stage, one for the gate of an external switch that disconnects the LED string, and one for an external switch in series with the input supply. It runs from a 1 MHz clock, and every delay it applies is a count of clock cycles.

After power-on reset, switching is held off for a start-up interval. A fault flag that stays high for a qualification window opens the input switch. Some faults then latch the block off. An input overvoltage instead releases the switch once the flag clears. Output overvoltage and die over-temperature each stop switching with hysteresis and restart on their own, using separate set and release flags. When the dimming input goes low, the load-isolation gate follows it at once, but full shutdown waits for a further interval. A latched fault is cleared by a low-then-high cycle of the dimming input.

Top module: `led_drv_supervisor`

## Requirements
- R1: `sw_en` stays low until `por_ok` has been high for START_CYC consecutive clocks. Whenever `por_ok` is low, the hold-off count restarts and `sw_en` is low on the next clock.
- R2: The monitored flags are `fb_under`, `fb_over`, `ovp_hi` and `vin_ov`. Once any of them has been high for QUAL_CYC consecutive clocks, the fault is qualified and `prot_sw_en` goes low. If all four flags are clear in any cycle, the count returns to zero.
- R3: A qualified fault in which `fb_under`, `fb_over` or `ovp_hi` is high latches the block off, unless `latch_dis` is high. The reason is recorded one-hot in `fault_code`: bit 0 for feedback under, bit 1 for feedback over, bit 2 for output overvoltage. When several of these flags are high, feedback under takes priority, then feedback over. While latched, `prot_sw_en` and `sw_en` are low, even after the flags clear.
- R4: A qualified fault caused by `vin_ov` alone never latches: `fault_code` stays 0, and `prot_sw_en` returns high on the clock after the flag clears.
- R5: A rising edge of the synchronized `en_pwm`, seen after at least one low sample, clears the latch and `fault_code` and restarts fault qualification.
- R6: While `latch_dis` is high, no fault latches, and `prot_sw_en` returns high once all monitored flags are clear.
- R7: `ovp_hi` stops switching. Switching resumes only after `ovp_below` is seen with `ovp_hi` low.
- R8: `die_hot` stops switching. Switching resumes only after `die_cool` is seen with `die_hot` low.
- R9: `en_pwm` passes through a two-flop synchronizer. `iso_gate` follows the synchronized value. After the synchronized `en_pwm` goes low, `sw_en` stays high for SHDN_CYC clocks, then the block shuts down.
- R10: `sw_en` is low while a fault is qualified, even if that fault does not latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1 MHz clock |
| rst_n | input | 1 | Active-low asynchronous reset (power cycle) |
| por_ok | input | 1 | Supply power-on reset complete |
| fb_under | input | 1 | Feedback below regulation window |
| fb_over | input | 1 | Feedback above regulation window |
| ovp_hi | input | 1 | Output above upper overvoltage threshold |
| ovp_below | input | 1 | Output below lower overvoltage threshold |
| vin_ov | input | 1 | Input supply overvoltage |
| die_hot | input | 1 | Die temperature above trip point |
| die_cool | input | 1 | Die temperature below release point |
| latch_dis | input | 1 | Strap that suppresses fault latching |
| en_pwm | input | 1 | Asynchronous enable and dimming input |
| sw_en | output | 1 | Power switching enable |
| iso_gate | output | 1 | LED string isolation gate enable |
| prot_sw_en | output | 1 | Input protection switch enable |
| fault_code | output | 3 | One-hot reason for the latched fault |

## Verification
Any error in a hysteresis flag, the latch or one of the three counters shows up on `sw_en` or `prot_sw_en` on the very clock the flag or count is wrong. The exception is a counter with the wrong value that is not yet at its terminal count: it only shows at the moment that count should have ended, one interval late or early. A wrong latch reason shows at once on `fault_code`. A wrong synchronizer or edge detector shows either as `iso_gate` out of step with `en_pwm` by more or less than two clocks, or as a latch that fails to clear on a toggle. The reference model steps alongside the block on every clock, so each of these faults is reported in the first cycle it is visible.

// File: rtl/led_drv_supervisor.sv
module led_drv_supervisor #(
  parameter int START_CYC = 1000,
  parameter int QUAL_CYC  = 50000,
  parameter int SHDN_CYC  = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_ok,
  input  logic       fb_under,
  input  logic       fb_over,
  input  logic       ovp_hi,
  input  logic       ovp_below,
  input  logic       vin_ov,
  input  logic       die_hot,
  input  logic       die_cool,
  input  logic       latch_dis,
  input  logic       en_pwm,
  output logic       sw_en,
  output logic       iso_gate,
  output logic       prot_sw_en,
  output logic [2:0] fault_code
);
  localparam int SW = $clog2(START_CYC + 1);
  localparam int QW = $clog2(QUAL_CYC + 1);
  localparam int DW = $clog2(SHDN_CYC + 1);

  logic          en_m, en_s, en_d;
  logic [SW-1:0] st_cnt;
  logic          ready;
  logic [DW-1:0] sd_cnt;
  logic          run;
  logic          ovp_blk, hot_blk;
  logic [QW-1:0] q_cnt;
  logic          latched;

  wire en_rise  = en_s & ~en_d;
  wire any_flt  = fb_under | fb_over | ovp_hi | vin_ov;
  wire latchable = fb_under | fb_over | ovp_hi;
  wire qual     = (q_cnt == QW'(QUAL_CYC));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {en_m, en_s, en_d} <= '0;
    else        {en_m, en_s, en_d} <= {en_pwm, en_m, en_s};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_cnt <= '0;
      ready  <= 1'b0;
    end else if (!por_ok) begin
      st_cnt <= '0;
      ready  <= 1'b0;
    end else if (!ready) begin
      if (st_cnt == SW'(START_CYC - 1)) ready <= 1'b1;
      else st_cnt <= st_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sd_cnt <= '0;
      run    <= 1'b0;
    end else if (en_s) begin
      sd_cnt <= '0;
      run    <= 1'b1;
    end else if (run) begin
      if (sd_cnt == DW'(SHDN_CYC - 1)) begin
        sd_cnt <= '0;
        run    <= 1'b0;
      end else sd_cnt <= sd_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ovp_blk <= 1'b0;
      hot_blk <= 1'b0;
    end else begin
      if (ovp_hi) ovp_blk <= 1'b1;
      else if (ovp_below) ovp_blk <= 1'b0;
      if (die_hot) hot_blk <= 1'b1;
      else if (die_cool) hot_blk <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q_cnt <= '0;
    else if (en_rise || !any_flt) q_cnt <= '0;
    else if (!qual) q_cnt <= q_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      latched    <= 1'b0;
      fault_code <= '0;
    end else if (en_rise) begin
      latched    <= 1'b0;
      fault_code <= '0;
    end else if (!latched && qual && !latch_dis && latchable) begin
      latched    <= 1'b1;
      fault_code <= fb_under ? 3'b001 : fb_over ? 3'b010 : 3'b100;
    end

  assign iso_gate   = en_s;
  assign prot_sw_en = ~latched & ~qual;
  assign sw_en      = run & ready & ~ovp_blk & ~hot_blk & ~latched & ~qual;

  // R1
  por_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !por_ok |=> !sw_en);
  // R3
  code_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fault_code));
  // R3
  latched_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code != 3'b000) |-> (!prot_sw_en && !sw_en));
  // R6
  no_latch_when_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_dis && fault_code == 3'b000) |=> (fault_code == 3'b000));
  // R7
  ovp_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_hi |=> !sw_en);
  // R8
  hot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    die_hot |=> !sw_en);
endmodule

// File: tb/led_drv_supervisor_test.sv
module led_drv_supervisor_test;
  localparam int CLK_PERIOD = 1000;
  localparam int ST = 8, QL = 12, SD = 10;

  logic clk = 0, rst_n = 0;
  logic por_ok = 0, fb_under = 0, fb_over = 0, ovp_hi = 0, ovp_below = 0;
  logic vin_ov = 0, die_hot = 0, die_cool = 0, latch_dis = 0, en_pwm = 0;
  logic sw_en, iso_gate, prot_sw_en;
  logic [2:0] fault_code;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  led_drv_supervisor #(.START_CYC(ST), .QUAL_CYC(QL), .SHDN_CYC(SD)) uut (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .fb_under(fb_under), .fb_over(fb_over),
    .ovp_hi(ovp_hi), .ovp_below(ovp_below), .vin_ov(vin_ov), .die_hot(die_hot),
    .die_cool(die_cool), .latch_dis(latch_dis), .en_pwm(en_pwm), .sw_en(sw_en),
    .iso_gate(iso_gate), .prot_sw_en(prot_sw_en), .fault_code(fault_code));

  // behavioural reference model
  bit sync_q[$];
  bit m_prev, m_ovp, m_hot, m_lat;
  int m_por_cnt, m_low_cnt, m_flt_cnt;
  bit m_on;
  int m_code;

  function automatic bit m_sync_out();
    return sync_q.size() == 2 ? sync_q[1] : 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      sync_q = {}; m_prev = 0; m_ovp = 0; m_hot = 0; m_lat = 0;
      m_por_cnt = 0; m_low_cnt = 0; m_flt_cnt = 0; m_on = 0; m_code = 0;
    end else begin
      bit s, rise, anyf, lf;
      s = m_sync_out();
      rise = s && !m_prev;
      anyf = fb_under || fb_over || ovp_hi || vin_ov;
      lf = fb_under || fb_over || ovp_hi;
      if (rise) begin m_lat = 0; m_code = 0; end
      else if (!m_lat && m_flt_cnt >= QL && !latch_dis && lf) begin
        m_lat = 1;
        m_code = fb_under ? 1 : (fb_over ? 2 : 4);
      end
      if (rise || !anyf) m_flt_cnt = 0;
      else if (m_flt_cnt < QL) m_flt_cnt++;
      m_por_cnt = por_ok ? (m_por_cnt < ST ? m_por_cnt + 1 : ST) : 0;
      if (s) begin m_on = 1; m_low_cnt = 0; end
      else if (m_on) begin
        m_low_cnt++;
        if (m_low_cnt >= SD) begin m_on = 0; m_low_cnt = 0; end
      end
      if (ovp_hi) m_ovp = 1; else if (ovp_below) m_ovp = 0;
      if (die_hot) m_hot = 1; else if (die_cool) m_hot = 0;
      m_prev = s;
      sync_q.push_front(en_pwm);
      if (sync_q.size() > 2) void'(sync_q.pop_back());
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    bit q, e_sw;
    q = m_flt_cnt >= QL;
    e_sw = m_on && (m_por_cnt >= ST) && !m_ovp && !m_hot && !m_lat && !q;
    chk("R10 sw_en model", sw_en, e_sw);
    chk("R9 iso_gate model", iso_gate, m_sync_out());
    chk("R2 prot_sw_en model", prot_sw_en, !m_lat && !q);
    chk("R3 fault_code model", fault_code, m_code);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle_en();
    en_pwm = 0; cyc(3); en_pwm = 1; cyc(4);
  endtask

  initial begin
    cyc(3);
    chk("R1 reset sw_en", sw_en, 0);
    chk("R2 reset prot", prot_sw_en, 1);
    chk("R3 reset code", fault_code, 0);
    rst_n = 1;
    en_pwm = 1; por_ok = 1;
    cyc(4);
    chk("R1 holdoff", sw_en, 0);
    cyc(10);
    chk("R1 running", sw_en, 1);
    ovp_hi = 1; cyc(2); ovp_hi = 0; cyc(3);
    chk("R7 held off", sw_en, 0);
    ovp_below = 1; cyc(1); ovp_below = 0; cyc(1);
    chk("R7 resumed", sw_en, 1);
    die_hot = 1; cyc(2); die_hot = 0; cyc(3);
    chk("R8 held off", sw_en, 0);
    die_cool = 1; cyc(1); die_cool = 0; cyc(1);
    chk("R8 resumed", sw_en, 1);
    vin_ov = 1; cyc(QL + 3);
    chk("R2 opened", prot_sw_en, 0);
    chk("R10 stop", sw_en, 0);
    chk("R4 no latch", fault_code, 0);
    vin_ov = 0; cyc(1);
    chk("R4 reclosed", prot_sw_en, 1);
    fb_over = 1; cyc(QL - 4); fb_over = 0; cyc(1); fb_over = 1; cyc(QL - 4); fb_over = 0; cyc(1);
    chk("R2 restart", prot_sw_en, 1);
    chk("R2 no latch", fault_code, 0);
    fb_under = 1; fb_over = 1; cyc(QL + 3); fb_under = 0; fb_over = 0; cyc(5);
    chk("R3 code under", fault_code, 1);
    chk("R3 stays open", prot_sw_en, 0);
    toggle_en();
    chk("R5 cleared", fault_code, 0);
    chk("R5 prot", prot_sw_en, 1);
    latch_dis = 1; ovp_hi = 1; cyc(QL + 3);
    chk("R6 no latch", fault_code, 0);
    chk("R6 opened", prot_sw_en, 0);
    ovp_hi = 0; ovp_below = 1; cyc(2); ovp_below = 0;
    chk("R6 reclosed", prot_sw_en, 1);
    latch_dis = 0;
    ovp_hi = 1; fb_over = 1; cyc(QL + 3); ovp_hi = 0; fb_over = 0; ovp_below = 1; cyc(2); ovp_below = 0;
    chk("R3 code over", fault_code, 2);
    toggle_en();
    ovp_hi = 1; cyc(QL + 3); ovp_hi = 0; ovp_below = 1; cyc(2); ovp_below = 0;
    chk("R3 code ovp", fault_code, 4);
    toggle_en();
    chk("R5 cleared again", fault_code, 0);
    cyc(2);
    chk("R1 resumed", sw_en, 1);
    en_pwm = 0; cyc(3);
    chk("R9 iso low", iso_gate, 0);
    cyc(3);
    chk("R9 still on", sw_en, 1);
    cyc(8);
    chk("R9 shut down", sw_en, 0);
    en_pwm = 1; cyc(4);
    chk("R9 back on", sw_en, 1);
    por_ok = 0; cyc(1);
    chk("R1 por drop", sw_en, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule